// File: doc/BRIEF.md
# Pulse Width Measurement Timer

This block times the high and low phases of a digital pulse train in units of prescaled clock ticks. One of several pulse lines is picked by a select input. The picked line is resynchronised into the clock domain, and its rising and falling edges are detected there. A counter runs between qualifying edges. Each time a qualifying edge arrives, the counter value is stored in one of two result registers and the count restarts from zero. One register holds widths that end on a falling edge (positive widths). The other holds widths that end on a rising edge (negative widths).

Three measurement intervals are available. In alternating mode, every edge ends one phase and starts the next, and a configurable start edge decides whether the high or the low phase is timed first. In rising-period mode, only rising edges count, and the full period is stored in the positive register. In falling-period mode, only falling edges count, and the full period is stored in the negative register.

The block has two sticky flags. One reports a fresh result. The other reports a phase too long for the counter. Such a phase is discarded, and timing resumes at the next start edge. Software or a neighbouring block reads the results and clears the flags with single-cycle pulses.

Top module: `pulse_span_meter`

## Requirements
- R1: After reset both result registers read 0 and both flags read 0.
- R2: Only the line of `pulse_i` whose index equals `in_sel_i` is measured. Edges on every other line leave the results and flags untouched.
- R3: With `mode_i` equal to 0 or 3 (alternating), once the start edge has been seen, each falling edge stores the length of the preceding high phase in `pos_width_o`. Each rising edge stores the length of the preceding low phase in `neg_width_o`.
- R4: `start_fall_i` = 0 makes a rising edge the start edge in alternating mode, and 1 makes a falling edge the start edge. Edges before the start edge store nothing.
- R5: With `mode_i` = 1, each rising edge after the first stores the rising-to-rising period in `pos_width_o`. Falling edges are ignored, and `neg_width_o` does not change.
- R6: With `mode_i` = 2, each falling edge after the first stores the falling-to-falling period in `neg_width_o`. Rising edges are ignored, and `pos_width_o` does not change.
- R7: A stored value equals floor(N / 2^k), where N is the measured interval in clock cycles and k is `psc_sel_i`.
- R8: `ready_o` sets on every store and stays set until a cycle with `rdy_clr_i` high. A store in the same cycle as the clear wins.
- R9: An interval of 2^CNT_W ticks or more sets `ovf_o`, stores nothing and leaves `ready_o` alone. Measurement restarts at the next start edge. `ovf_o` stays set until a cycle with `ovf_clr_i` high.
- R10: While `enable_i` is low no store happens and the running measurement is dropped. After `enable_i` rises, a start edge is needed before anything is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| enable_i | input | 1 | Measurement enable |
| pulse_i | input | NUM_IN | Candidate pulse lines |
| in_sel_i | input | IN_SEL_W | Index of the measured line |
| psc_sel_i | input | PSC_SEL_W | Prescaler exponent k, tick every 2^k cycles |
| mode_i | input | 2 | 0/3 alternating, 1 rising period, 2 falling period |
| start_fall_i | input | 1 | Start edge in alternating mode: 0 rising, 1 falling |
| rdy_clr_i | input | 1 | Clears the new-result flag |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| pos_width_o | output | CNT_W | Width ending on a falling edge / rising period |
| neg_width_o | output | CNT_W | Width ending on a rising edge / falling period |
| ready_o | output | 1 | New result flag |
| ovf_o | output | 1 | Counter overflow flag |

## Verification
The bench builds the block with a 6-bit counter, a 2-bit prescaler select (divide by 1 to 8) and four input lines. With these values, every count from 0 to 63 and the overflow boundary at 64 ticks can be reached in a few hundred cycles for each divider. The bench sweeps phase lengths across all four dividers, both start edges and all four lines. Expected values are computed as N shifted right by k, with the exact 63/64 tick boundary tested at each divider.

// File: rtl/psm_pkg.sv
package psm_pkg;

  typedef enum logic [1:0] {
    MODE_ALT   = 2'd0,
    MODE_RISE  = 2'd1,
    MODE_FALL  = 2'd2,
    MODE_ALT_B = 2'd3
  } psm_mode_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } psm_edge_t;

endpackage

// File: rtl/psm_in_sync.sv
module psm_in_sync
  import psm_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int SEL_W   = 2,
  parameter int STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] pulse_i,
  input  logic [SEL_W-1:0]  sel_i,
  output psm_edge_t         edge_o
);

  logic              picked;
  logic [STAGES-1:0] sync_d;
  logic [STAGES-1:0] sync_q;
  logic              level;
  logic              last_d;
  logic              last_q;

  always_comb begin
    picked = pulse_i[sel_i];
  end

  // synchronizer chain: stage 0 samples the picked line, each later stage the one before
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign sync_d[g] = picked;
    end else begin : g_next
      assign sync_d[g] = sync_q[g-1];
    end
  end

  always_comb begin
    level       = sync_q[STAGES-1];
    last_d      = level;
    edge_o.rise = level & ~last_q;
    edge_o.fall = ~level & last_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

endmodule

// File: rtl/psm_prescaler.sv
module psm_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);

  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] mask;
  logic [DIV_W-1:0] div_d;
  logic [DIV_W-1:0] div_q;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) begin
      mask[i] = (i < int'(sel_i));
    end
    tick_o = run_i && ((div_q & mask) == mask);
    if (!run_i || restart_i || tick_o) begin
      div_d = '0;
    end else begin
      div_d = div_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

endmodule

// File: rtl/psm_measure.sv
module psm_measure
  import psm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  psm_mode_e        mode_i,
  input  logic             start_fall_i,
  input  psm_edge_t        edge_i,
  input  logic             tick_i,
  input  logic             rdy_clr_i,
  input  logic             ovf_clr_i,
  output logic             running_o,
  output logic             restart_o,
  output logic [CNT_W-1:0] pos_o,
  output logic [CNT_W-1:0] neg_o,
  output logic             ready_o,
  output logic             ovf_o
);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] pos_q, pos_d;
  logic [CNT_W-1:0] neg_q, neg_d;
  logic             rdy_q, rdy_d;
  logic             ovf_q, ovf_d;

  logic             start_hit;
  logic             meas_hit;
  logic             to_pos;
  logic             cnt_full;
  logic             ovf_evt;
  logic             capture;
  logic [CNT_W-1:0] cap_val;

  // edge qualification per mode
  always_comb begin
    unique case (mode_i)
      MODE_RISE: begin
        start_hit = edge_i.rise;
        meas_hit  = edge_i.rise;
        to_pos    = 1'b1;
      end
      MODE_FALL: begin
        start_hit = edge_i.fall;
        meas_hit  = edge_i.fall;
        to_pos    = 1'b0;
      end
      default: begin
        start_hit = start_fall_i ? edge_i.fall : edge_i.rise;
        meas_hit  = edge_i.rise | edge_i.fall;
        to_pos    = edge_i.fall;
      end
    endcase
  end

  // next-state logic
  always_comb begin
    cnt_full  = &cnt_q;
    ovf_evt   = enable_i && run_q && tick_i && cnt_full;
    capture   = enable_i && run_q && meas_hit && !ovf_evt;
    cap_val   = cnt_q + CNT_W'(tick_i);
    restart_o = enable_i && (run_q ? meas_hit : start_hit);

    run_d = run_q;
    if (!enable_i || ovf_evt) begin
      run_d = 1'b0;
    end else if (!run_q && start_hit) begin
      run_d = 1'b1;
    end

    cnt_d = cnt_q;
    if (!enable_i || !run_q || restart_o) begin
      cnt_d = '0;
    end else if (tick_i && !cnt_full) begin
      cnt_d = cnt_q + CNT_W'(1);
    end

    pos_d = pos_q;
    neg_d = neg_q;
    if (capture && to_pos) begin
      pos_d = cap_val;
    end
    if (capture && !to_pos) begin
      neg_d = cap_val;
    end

    rdy_d = rdy_q;
    if (capture) begin
      rdy_d = 1'b1;
    end else if (rdy_clr_i) begin
      rdy_d = 1'b0;
    end

    ovf_d = ovf_q;
    if (ovf_evt) begin
      ovf_d = 1'b1;
    end else if (ovf_clr_i) begin
      ovf_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      pos_q <= '0;
      neg_q <= '0;
      rdy_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
      if (capture) begin
        pos_q <= pos_d;
        neg_q <= neg_d;
      end
      rdy_q <= rdy_d;
      ovf_q <= ovf_d;
    end
  end

  always_comb begin
    running_o = run_q;
    pos_o     = pos_q;
    neg_o     = neg_q;
    ready_o   = rdy_q;
    ovf_o     = ovf_q;
  end

endmodule

// File: rtl/pulse_span_meter.sv
module pulse_span_meter
  import psm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PSC_SEL_W   = 3,
  parameter int NUM_IN      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int IN_SEL_W    = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 enable_i,
  input  logic [NUM_IN-1:0]    pulse_i,
  input  logic [IN_SEL_W-1:0]  in_sel_i,
  input  logic [PSC_SEL_W-1:0] psc_sel_i,
  input  logic [1:0]           mode_i,
  input  logic                 start_fall_i,
  input  logic                 rdy_clr_i,
  input  logic                 ovf_clr_i,
  output logic [CNT_W-1:0]     pos_width_o,
  output logic [CNT_W-1:0]     neg_width_o,
  output logic                 ready_o,
  output logic                 ovf_o
);

  psm_edge_t edges;
  logic      running;
  logic      restart;
  logic      tick;
  psm_mode_e mode;

  always_comb begin
    mode = psm_mode_e'(mode_i);
  end

  psm_in_sync #(
    .NUM_IN (NUM_IN),
    .SEL_W  (IN_SEL_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pulse_i (pulse_i),
    .sel_i   (in_sel_i),
    .edge_o  (edges)
  );

  psm_prescaler #(
    .SEL_W (PSC_SEL_W)
  ) u_psc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (running),
    .restart_i (restart),
    .sel_i     (psc_sel_i),
    .tick_o    (tick)
  );

  psm_measure #(
    .CNT_W (CNT_W)
  ) u_meas (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (enable_i),
    .mode_i       (mode),
    .start_fall_i (start_fall_i),
    .edge_i       (edges),
    .tick_i       (tick),
    .rdy_clr_i    (rdy_clr_i),
    .ovf_clr_i    (ovf_clr_i),
    .running_o    (running),
    .restart_o    (restart),
    .pos_o        (pos_width_o),
    .neg_o        (neg_width_o),
    .ready_o      (ready_o),
    .ovf_o        (ovf_o)
  );

endmodule

// File: rtl/psm_checker.sv
module psm_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic [1:0]       mode_i,
  input logic [CNT_W-1:0] pos_width_o,
  input logic [CNT_W-1:0] neg_width_o,
  input logic             ready_o,
  input logic             ovf_o
);

  AST_RESET_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (pos_width_o == '0) && (neg_width_o == '0) && !ready_o && !ovf_o); // R1

  AST_UPDATE_SETS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(pos_width_o) || !$stable(neg_width_o)) |-> ready_o); // R8

  AST_OVERFLOW_KEEPS_RESULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $stable(pos_width_o) && $stable(neg_width_o)); // R9

  AST_DISABLED_NO_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(enable_i) |-> $stable(pos_width_o) && $stable(neg_width_o) && !$rose(ready_o)); // R10

  AST_RISE_MODE_NEG_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) == 2'd1) |-> $stable(neg_width_o)); // R5

  AST_FALL_MODE_POS_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) == 2'd2) |-> $stable(pos_width_o)); // R6

endmodule

bind pulse_span_meter psm_checker #(.CNT_W(CNT_W)) u_psm_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .mode_i      (mode_i),
  .pos_width_o (pos_width_o),
  .neg_width_o (neg_width_o),
  .ready_o     (ready_o),
  .ovf_o       (ovf_o)
);

// File: tb/tb_pulse_span_meter.sv
module tb_pulse_span_meter;

  localparam int CNT_W = 6;
  localparam int PSW   = 2;
  localparam int NIN   = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n;
  logic             enable;
  logic [NIN-1:0]   pins;
  logic [1:0]       in_sel;
  logic [PSW-1:0]   psc_sel;
  logic [1:0]       mode;
  logic             start_fall;
  logic             rdy_clr;
  logic             ovf_clr;
  logic [CNT_W-1:0] pos_w;
  logic [CNT_W-1:0] neg_w;
  logic             ready;
  logic             ovf;

  int checks = 0;
  int fails  = 0;

  pulse_span_meter #(
    .CNT_W     (CNT_W),
    .PSC_SEL_W (PSW),
    .NUM_IN    (NIN)
  ) dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .enable_i     (enable),
    .pulse_i      (pins),
    .in_sel_i     (in_sel),
    .psc_sel_i    (psc_sel),
    .mode_i       (mode),
    .start_fall_i (start_fall),
    .rdy_clr_i    (rdy_clr),
    .ovf_clr_i    (ovf_clr),
    .pos_width_o  (pos_w),
    .neg_width_o  (neg_w),
    .ready_o      (ready),
    .ovf_o        (ovf)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setpin(input logic v);
    pins[in_sel] = v;
  endtask

  task automatic clear_ready();
    rdy_clr = 1'b1;
    idle(1);
    rdy_clr = 1'b0;
  endtask

  task automatic clear_ovf();
    ovf_clr = 1'b1;
    idle(1);
    ovf_clr = 1'b0;
  endtask

  task automatic arm(input int line, input int k, input int m, input logic sf, input logic lvl);
    enable = 1'b0;
    idle(1);
    in_sel     = 2'(line);
    psc_sel    = PSW'(k);
    mode       = 2'(m);
    start_fall = sf;
    pins       = '0;
    pins[line] = lvl;
    idle(5);
    clear_ready();
    enable = 1'b1;
    idle(2);
  endtask

  // alternating mode: one high phase of hi cycles and one low phase of lo cycles
  task automatic trial_alt(input int line, input int k, input int m, input logic sf,
                           input int hi, input int lo);
    if (!sf) begin
      arm(line, k, m, sf, 1'b0);
      setpin(1'b1); idle(hi);
      setpin(1'b0); idle(lo);
      setpin(1'b1); idle(5);
    end else begin
      arm(line, k, m, sf, 1'b1);
      setpin(1'b0); idle(lo);
      setpin(1'b1); idle(hi);
      setpin(1'b0); idle(5);
    end
    chk($sformatf("R3 R7 pos k=%0d hi=%0d", k, hi), int'(pos_w), hi >> k);
    chk($sformatf("R3 R7 neg k=%0d lo=%0d", k, lo), int'(neg_w), lo >> k);
    chk("R8 ready after store", int'(ready), 1);
  endtask

  task automatic trial_overflow(input int k);
    int pos_before;
    arm(0, k, 0, 1'b0, 1'b0);
    pos_before = int'(pos_w);
    setpin(1'b1); idle((1 << CNT_W) << k);
    setpin(1'b0); idle(5);
    chk($sformatf("R9 ovf set k=%0d", k), int'(ovf), 1);
    chk("R9 ready untouched", int'(ready), 0);
    chk("R9 pos unchanged", int'(pos_w), pos_before);
    idle(6);
    setpin(1'b1); idle(12 << k);
    setpin(1'b0); idle(5);
    chk("R9 resumes after overflow", int'(pos_w), 12);
    chk("R9 ovf sticky", int'(ovf), 1);
    clear_ovf();
    chk("R9 ovf cleared", int'(ovf), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int before_a;
    int before_b;
    rst_n      = 1'b0;
    enable     = 1'b0;
    pins       = '0;
    in_sel     = '0;
    psc_sel    = '0;
    mode       = '0;
    start_fall = 1'b0;
    rdy_clr    = 1'b0;
    ovf_clr    = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 pos reset", int'(pos_w), 0);
    chk("R1 neg reset", int'(neg_w), 0);
    chk("R1 ready reset", int'(ready), 0);
    chk("R1 ovf reset", int'(ovf), 0);

    // R3 R7 sweep over dividers, phase lengths, lines, start edges, modes 0 and 3
    for (int k = 0; k < (1 << PSW); k++) begin
      for (int i = 0; i < 13; i++) begin
        int hi = ((1 + 5 * i) << k) + (i % (1 << k));
        int lo = ((64 - (1 + 5 * i)) << k) - 1 + ((i % 2) << k);
        if (lo < 1) lo = 1;
        if ((lo >> k) > 63) lo = (64 << k) - 1;
        trial_alt(i % NIN, k, (i % 4 == 3) ? 3 : 0, 1'(i % 2), hi, lo);
      end
      // boundary: largest storable interval
      trial_alt(k, k, 0, 1'b0, (64 << k) - 1, 1);
      trial_overflow(k);
    end

    // R8 clear, and store wins only when a store happens
    clear_ready();
    chk("R8 ready cleared", int'(ready), 0);

    // R4 falling start: a rising edge first stores nothing
    arm(1, 0, 0, 1'b1, 1'b0);
    setpin(1'b1); idle(8);
    chk("R4 rise ignored before falling start", int'(ready), 0);
    setpin(1'b0); idle(17);
    setpin(1'b1); idle(9);
    chk("R4 first store goes to neg", int'(neg_w), 17);
    setpin(1'b0); idle(5);
    chk("R4 pos after falling start", int'(pos_w), 9);

    // R4 rising start: a falling edge first stores nothing
    arm(2, 1, 0, 1'b0, 1'b1);
    setpin(1'b0); idle(8);
    chk("R4 fall ignored before rising start", int'(ready), 0);
    setpin(1'b1); idle(22);
    setpin(1'b0); idle(30);
    setpin(1'b1); idle(5);
    chk("R4 pos after rising start", int'(pos_w), 11);
    chk("R4 neg after rising start", int'(neg_w), 15);

    // R5 rising period mode
    for (int k = 0; k < 3; k++) begin
      arm(3, k, 1, 1'b0, 1'b0);
      before_b = int'(neg_w);
      setpin(1'b1); idle(7 + 3 * k);
      setpin(1'b0); idle(13);
      setpin(1'b1); idle(5);
      chk($sformatf("R5 period k=%0d", k), int'(pos_w), (20 + 3 * k) >> k);
      chk("R5 neg untouched", int'(neg_w), before_b);
    end

    // R6 falling period mode
    for (int k = 0; k < 3; k++) begin
      arm(0, k, 2, 1'b0, 1'b1);
      before_a = int'(pos_w);
      setpin(1'b0); idle(9);
      setpin(1'b1); idle(15 + 5 * k);
      setpin(1'b0); idle(5);
      chk($sformatf("R6 period k=%0d", k), int'(neg_w), (24 + 5 * k) >> k);
      chk("R6 pos untouched", int'(pos_w), before_a);
    end

    // R2 other lines ignored
    arm(2, 0, 0, 1'b0, 1'b0);
    before_a = int'(pos_w);
    before_b = int'(neg_w);
    for (int t = 0; t < 6; t++) begin
      pins[0] = ~pins[0];
      pins[1] = 1'(t % 2);
      pins[3] = ~pins[3];
      idle(4 + t);
    end
    chk("R2 ready idle on other lines", int'(ready), 0);
    chk("R2 pos idle on other lines", int'(pos_w), before_a);
    chk("R2 neg idle on other lines", int'(neg_w), before_b);
    setpin(1'b1); idle(19);
    pins[0] = ~pins[0];
    setpin(1'b0); idle(5);
    chk("R2 selected line measured", int'(pos_w), 19);

    // R10 disabled: edges ignored, restart needs a start edge
    arm(1, 0, 0, 1'b0, 1'b0);
    enable = 1'b0;
    before_a = int'(pos_w);
    before_b = int'(neg_w);
    setpin(1'b1); idle(6);
    setpin(1'b0); idle(6);
    setpin(1'b1); idle(6);
    chk("R10 pos held while disabled", int'(pos_w), before_a);
    chk("R10 neg held while disabled", int'(neg_w), before_b);
    chk("R10 ready idle while disabled", int'(ready), 0);
    enable = 1'b1;
    idle(3);
    setpin(1'b0); idle(6);
    chk("R10 no store without start edge", int'(ready), 0);
    setpin(1'b1); idle(9);
    setpin(1'b0); idle(5);
    chk("R10 store after start edge", int'(pos_w), 9);

    // R10 drop in-flight measurement when disabled mid-phase
    arm(3, 0, 0, 1'b0, 1'b0);
    setpin(1'b1); idle(10);
    enable = 1'b0; idle(3);
    enable = 1'b1; idle(2);
    setpin(1'b0); idle(5);
    chk("R10 dropped measurement stores nothing", int'(ready), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule